// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the end-of-transfer events of up to 64 DMA channels into one place. Software reaches it through a 32-bit register window. Each channel raises a one-cycle completion pulse. The pulse latches a sticky pending bit, and that bit stays set until software acknowledges it by writing a 1 to the matching bit of an acknowledge register. A separate enable register selects which pending bits may raise an interrupt. The block drives one interrupt request per channel and one combined request that is the OR of all of them.

The per-channel bits are split across two 32-bit words. Channels 0 to 31 sit in the low word at bit n. Channels 32 to 63 sit in the high word at bit n-32. The pending, acknowledge, enable and activity words each use such a pair.

The block also has one soft-reset register per channel. Writing 1 to that register sends a one-cycle reset strobe to the channel and drops the channel's pending bit. The activity words are a read-only view of the channels' busy inputs. The DMA channels themselves are outside this block.

Top module: `dma_irq_hub`

## Requirements
- R1: After reset, every pending bit, every enable bit and every reset strobe is 0, and no interrupt output is asserted.
- R2: A completion pulse on channel n sets pending bit n at the next clock edge. The bit reads back at offset 0x0C bit n for n < 32, or at offset 0x10 bit n-32 otherwise. It stays set until it is cleared.
- R3: A write to offset 0x14 (channels 0-31) or 0x18 (channels 32-63) clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R4: When a completion pulse and a clear (acknowledge or soft reset) hit the same channel in the same cycle, the pending bit ends up set.
- R5: The enable words at offsets 0x1C (channels 0-31) and 0x20 (channels 32-63) take the full written data at the next clock edge and read back unchanged.
- R6: ch_irq_o[n] is pending bit n AND enable bit n. irq_o is high exactly when any ch_irq_o bit is high.
- R7: Writes to the pending words at 0x0C and 0x10 have no effect.
- R8: Offsets 0x24 and 0x28 return chan_busy_i[31:0] and chan_busy_i[63:32].
- R9: A write with data bit 0 = 1 to offset 0x40 + 4*n asserts ch_rst_o[n] for exactly the one cycle after the write and clears pending bit n. With data bit 0 = 0 the write does nothing.
- R10: Reads from the acknowledge words, the soft-reset registers and any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_done_i | input | 64 | One-cycle completion pulse per channel |
| chan_busy_i | input | 64 | Channel activity flags, read-only view |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |
| ch_irq_o | output | 64 | Per-channel interrupt requests |
| ch_rst_o | output | 64 | Per-channel one-cycle soft-reset strobes |

## Verification
The assertions check on every cycle the rules that govern each pending and enable word. A pulsed bit is set on the next cycle. A bit that was pending and not cleared stays pending. A cleared bit falls unless a pulse arrives with the clear. An enable word holds between writes. The reset strobes are at most one-hot and follow only soft-reset writes. The bench scenarios cover the parts an assertion cannot see: the address decode and the bit placement across the low and high words, the read-back of every word, the ignored writes to pending words, the reads that return zero, and long random mixes of pulses, acknowledges, enable updates and soft resets checked against a reference model.

// File: rtl/dma_irq_hub_pkg.sv
package dma_irq_hub_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] PEND_OFS = 12'h00C;
    localparam logic [ADDR_W-1:0] ACK_OFS  = 12'h014;
    localparam logic [ADDR_W-1:0] ENA_OFS  = 12'h01C;
    localparam logic [ADDR_W-1:0] BUSY_OFS = 12'h024;
    localparam logic [ADDR_W-1:0] SRST_OFS = 12'h040;

    typedef struct packed {
        logic [WORD_W-1:0] pend;
        logic [WORD_W-1:0] ena;
    } bank_state_t;

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base, input int k);
        return base + ADDR_W'(4 * k);
    endfunction
endpackage

// File: rtl/irq_word_bank.sv
module irq_word_bank
    import dma_irq_hub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_i,
    input  logic [WORD_W-1:0] clr_i,
    input  logic              ena_wr_i,
    input  logic [WORD_W-1:0] ena_data_i,
    output logic [WORD_W-1:0] pend_o,
    output logic [WORD_W-1:0] ena_o,
    output logic [WORD_W-1:0] req_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
        if (ena_wr_i) begin
            st_d.ena = ena_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign ena_o  = st_q.ena;
    assign req_o  = st_q.pend & st_q.ena;

    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(set_i)) == $past(set_i)));
    p_pend_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(pend_o & ~clr_i)) == $past(pend_o & ~clr_i)));
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
    p_set_beats_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & clr_i)) |=> ((pend_o & $past(set_i & clr_i)) == $past(set_i & clr_i)));
    p_ena_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ena_wr_i |=> (ena_o == $past(ena_data_i)));
    p_ena_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr_i |=> $stable(ena_o));
endmodule

// File: rtl/chan_reset_strobe.sv
module chan_reset_strobe #(
    parameter int NUM_CH = 64,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [CH_W-1:0]   idx_i,
    output logic [NUM_CH-1:0] strobe_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] strobe;
    } srst_state_t;

    srst_state_t st_d, st_q;

    always_comb begin
        st_d.strobe = '0;
        if (fire_i) begin
            st_d.strobe[idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

    p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobe_o));
    p_strobe_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> strobe_o[$past(idx_i)]);
    p_strobe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (strobe_o == '0));
endmodule

// File: rtl/dma_irq_hub.sv
module dma_irq_hub
    import dma_irq_hub_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] xfer_done_i,
    input  logic [NUM_CH-1:0] chan_busy_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [NUM_CH-1:0] ch_irq_o,
    output logic [NUM_CH-1:0] ch_rst_o
);
    localparam int NUM_WORDS = (NUM_CH + WORD_W - 1) / WORD_W;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam logic [ADDR_W-1:0] SRST_END = SRST_OFS + ADDR_W'(4 * NUM_CH);

    logic [NUM_CH-1:0]    ack_vec;
    logic [NUM_CH-1:0]    srst_clr;
    logic [NUM_CH-1:0]    clr_all;
    logic [NUM_WORDS-1:0] ena_wr;
    logic [NUM_CH-1:0]    pend_all;
    logic [NUM_CH-1:0]    ena_all;
    logic                 srst_hit;
    logic                 srst_fire;
    logic [ADDR_W-1:0]    srst_rel;
    logic [CH_W-1:0]      srst_idx;

    // soft-reset window decode
    always_comb begin
        srst_rel  = addr_i - SRST_OFS;
        srst_idx  = srst_rel[CH_W+1:2];
        srst_hit  = (addr_i >= SRST_OFS) && (addr_i < SRST_END) && (addr_i[1:0] == 2'b00);
        srst_fire = wr_en_i && srst_hit && wdata_i[0];
        srst_clr  = '0;
        if (srst_fire) begin
            srst_clr[srst_idx] = 1'b1;
        end
    end

    // acknowledge and enable write decode
    always_comb begin
        ack_vec = '0;
        ena_wr  = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (wr_en_i && addr_i == word_addr(ACK_OFS, k)) begin
                ack_vec[k*WORD_W +: WORD_W] = wdata_i;
            end
            if (wr_en_i && addr_i == word_addr(ENA_OFS, k)) begin
                ena_wr[k] = 1'b1;
            end
        end
    end

    assign clr_all = ack_vec | srst_clr;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_bank
        irq_word_bank i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (xfer_done_i[g*WORD_W +: WORD_W]),
            .clr_i      (clr_all[g*WORD_W +: WORD_W]),
            .ena_wr_i   (ena_wr[g]),
            .ena_data_i (wdata_i),
            .pend_o     (pend_all[g*WORD_W +: WORD_W]),
            .ena_o      (ena_all[g*WORD_W +: WORD_W]),
            .req_o      (ch_irq_o[g*WORD_W +: WORD_W])
        );
    end

    chan_reset_strobe #(.NUM_CH(NUM_CH)) i_srst (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (srst_fire),
        .idx_i    (srst_idx),
        .strobe_o (ch_rst_o)
    );

    assign irq_o = |ch_irq_o;

    // read mux; unmapped offsets return zero
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (addr_i == word_addr(PEND_OFS, k)) rdata_o = pend_all[k*WORD_W +: WORD_W];
            if (addr_i == word_addr(ENA_OFS, k))  rdata_o = ena_all[k*WORD_W +: WORD_W];
            if (addr_i == word_addr(BUSY_OFS, k)) rdata_o = chan_busy_i[k*WORD_W +: WORD_W];
        end
    end

    p_pend_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == PEND_OFS) && (xfer_done_i == '0)) |=> $stable(pend_all));
    p_irq_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_all & ena_all) != '0);
    p_strobe_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rst_o != '0) |-> ((pend_all & ch_rst_o & ~$past(xfer_done_i)) == '0));
endmodule

// File: tb/test_dma_irq_hub.sv
`timescale 1ns/1ps
module test_dma_irq_hub;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] xfer_done;
    logic [63:0] chan_busy;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    logic [63:0] ch_irq;
    logic [63:0] ch_rst;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    logic [63:0] m_pend = '0;
    logic [63:0] m_ena  = '0;
    logic [63:0] m_rst  = '0;

    always #4 clk = ~clk;

    dma_irq_hub i_dma_irq_hub (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_done_i (xfer_done),
        .chan_busy_i (chan_busy),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .irq_o       (irq),
        .ch_irq_o    (ch_irq),
        .ch_rst_o    (ch_rst)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #0.3;
        chk(req, {32'b0, rdata}, {32'b0, exp});
    endtask

    function automatic logic [31:0] exp_word(input logic [11:0] a);
        case (a)
            12'h00C: return m_pend[31:0];
            12'h010: return m_pend[63:32];
            12'h01C: return m_ena[31:0];
            12'h020: return m_ena[63:32];
            12'h024: return chan_busy[31:0];
            12'h028: return chan_busy[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model(input logic [63:0] dn, input logic wr, input logic [11:0] a, input logic [31:0] d);
        logic [63:0] clr = '0;
        m_rst = '0;
        if (wr) begin
            if (a == 12'h014) clr[31:0] = d;
            if (a == 12'h018) clr[63:32] = d;
            if (a == 12'h01C) m_ena[31:0] = d;
            if (a == 12'h020) m_ena[63:32] = d;
            if (a >= 12'h040 && a < 12'h140 && a[1:0] == 2'b00 && d[0]) begin
                clr[(a - 12'h040) >> 2] = 1'b1;
                m_rst[(a - 12'h040) >> 2] = 1'b1;
            end
        end
        m_pend = (m_pend & ~clr) | dn;
    endtask

    task automatic check_all();
        chk("R6 ch_irq", ch_irq, m_pend & m_ena);
        chk("R6 irq", {63'b0, irq}, {63'b0, |(m_pend & m_ena)});
        chk("R9 ch_rst", ch_rst, m_rst);
        rd("R2 pend lo", 12'h00C, exp_word(12'h00C));
        rd("R2 pend hi", 12'h010, exp_word(12'h010));
        rd("R5 ena lo", 12'h01C, exp_word(12'h01C));
        rd("R5 ena hi", 12'h020, exp_word(12'h020));
        rd("R8 busy lo", 12'h024, exp_word(12'h024));
        rd("R8 busy hi", 12'h028, exp_word(12'h028));
    endtask

    task automatic step(input logic [63:0] dn, input logic wr, input logic [11:0] a, input logic [31:0] d);
        xfer_done = dn;
        wr_en     = wr;
        addr      = a;
        wdata     = d;
        @(posedge clk);
        model(dn, wr, a, d);
        #1;
        xfer_done = '0;
        wr_en     = 1'b0;
        check_all();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] dn;
        logic [11:0] a;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; xfer_done = '0; chan_busy = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pend", {32'b0, exp_word(12'h00C)}, 64'h0);
        check_all();

        // R2: low and high word placement
        step(64'h0000_0001_0000_0008, 1'b0, 12'h000, 32'h0);
        step(64'h0, 1'b0, 12'h000, 32'h0);
        // R7: write to pending word is ignored
        step(64'h0, 1'b1, 12'h00C, 32'hFFFF_FFFF);
        step(64'h0, 1'b1, 12'h010, 32'h0);
        // R5/R6: enable channel 32 only
        step(64'h0, 1'b1, 12'h020, 32'h0000_0001);
        // R3: zero bits have no effect, one bits clear
        step(64'h0, 1'b1, 12'h014, 32'h0000_0000);
        step(64'h0, 1'b1, 12'h018, 32'h0000_0001);
        // R4: set and clear on channel 5 in the same cycle
        step(64'h20, 1'b0, 12'h000, 32'h0);
        step(64'h20, 1'b1, 12'h014, 32'h0000_0020);
        // R4 via soft reset of channel 5 with a pulse
        step(64'h20, 1'b1, 12'h054, 32'h1);
        // R9: soft reset channel 3 clears its pending bit, strobe one cycle
        step(64'h0, 1'b1, 12'h04C, 32'h1);
        step(64'h0, 1'b0, 12'h000, 32'h0);
        // R9: bit0 = 0 does nothing; channel 63 fires
        step(64'h8000_0000_0000_0000, 1'b1, 12'h13C, 32'hFFFF_FFFE);
        step(64'h0, 1'b1, 12'h13C, 32'h1);
        // R10: zero reads
        rd("R10 ack lo", 12'h014, 32'h0);
        rd("R10 ack hi", 12'h018, 32'h0);
        rd("R10 srst", 12'h040, 32'h0);
        rd("R10 unmapped", 12'h2A0, 32'h0);
        @(negedge clk);

        for (int i = 0; i < 600; i++) begin
            chan_busy = {$urandom, $urandom};
            dn = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            d  = $urandom;
            case ($urandom % 7)
                0: a = 12'h000;
                1: a = ($urandom % 2) ? 12'h014 : 12'h018;
                2: a = ($urandom % 2) ? 12'h01C : 12'h020;
                3: a = 12'h040 + 12'(4 * ($urandom % 64));
                4: a = ($urandom % 2) ? 12'h00C : 12'h010;
                5: a = 12'h200 + 12'($urandom % 64);
                default: a = 12'h040 + 12'(4 * ($urandom % 64)) + 12'($urandom % 4);
            endcase
            step(dn, ($urandom % 4) != 0, a, d);
        end
        finish_run();
    end
endmodule